// File: doc/BRIEF.md
# Configurable ALU Cell for a Coarse-Grained Array

This block is one processing cell of a coarse-grained reconfigurable array with a 16-bit datapath. Each of its two operands comes from its own selector. A selector picks one of five neighbour outputs, a constant held in the configuration, a feedback path carrying the cell's own result, or zero. The ALU then adds, subtracts, multiplies, or applies a bitwise function to the two operands.

The operands can each be taken through a register or straight through, and the same holds for the result. Which path is used, the operand sources, the opcode, the constant and the feedback tap are all fields of one 33-bit configuration word. That word is captured when a context-switch strobe is sampled high.

The array places cells on a torus, and the neighbour inputs of a cell on the array edge are wired to the cells on the opposite edge. That wiring lives in the array, not here. The cell only presents its result on `cell_out`, which its neighbours read.

Top module: `rcell`

## Requirements
- R1: The configuration word is captured on a rising edge at which `ctx_switch` is high, and it governs the cell from that edge on. While `ctx_switch` is low, changes on `ctx_word` have no effect. The field layout is: bits 2:0 select operand A, bits 5:3 select operand B, bits 8:6 hold the opcode, bit 9 registers operand A, bit 10 registers operand B, bit 11 registers the result, bit 12 is the feedback tap, bits 28:13 hold the constant, and bits 32:29 are spare.
- R2: The operand select codes are 0 north, 1 north-east, 2 north-west, 3 west, 4 south, 5 the constant, 6 feedback and 7 zero.
- R3: The opcodes are 0 A+B, 1 A-B, 2 A*B, 3 A AND B, 4 A OR B, 5 NOT A, 6 A NOR B. Opcode 7 yields zero.
- R4: Add, subtract and multiply keep only the low 16 bits of the result, so they wrap modulo 2^16.
- R5: With bit 11 set, `cell_out` shows the ALU result captured at the previous rising edge. With bit 11 clear, `cell_out` follows the operands combinationally.
- R6: With its register bit set, an operand is the value its selector produced at the previous rising edge. With the bit clear, the operand follows the selector combinationally.
- R7: With the feedback tap (bit 12) set, select code 6 yields the result captured at the previous edge. With a constant as the other operand under add, the result therefore steps by that constant every cycle.
- R8: With bit 12 clear, select code 6 yields the present, unregistered ALU result, and that value enters the operand register. If that operand's register is off, code 6 falls back to the previous edge's result, so no combinational loop forms.
- R9: A context switch does not clear the operand or result registers. The first cycle after the switch still shows what the old configuration computed.
- R10: Reset loads an all-zero configuration and zeroes the operand and result registers. The cell then outputs north plus north, unregistered.
- R11: The four spare bits of the configuration word have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_switch | input | 1 | Strobe that loads `ctx_word` as the active configuration |
| ctx_word | input | 33 | Configuration word for the next context |
| nb_n | input | 16 | Output of the north neighbour |
| nb_ne | input | 16 | Output of the north-east neighbour |
| nb_nw | input | 16 | Output of the north-west neighbour |
| nb_w | input | 16 | Output of the west neighbour |
| nb_s | input | 16 | Output of the south neighbour |
| cell_out | output | 16 | Cell result presented to the neighbours |

## Verification
The bench builds the cell with its default package values: a 16-bit datapath, 3-bit operand selects, a 3-bit opcode and a 33-bit configuration word. At this width, every one of the eight select codes and eight opcodes can be reached from a short table of vectors. Add, subtract and multiply wraparound can be forced with small operands. The feedback loops step by a visible constant each cycle, which makes the two feedback taps easy to tell apart. The one-cycle delays of each register option, the strobe timing, and the pipeline surviving a context switch are each driven as short directed sequences.

// File: rtl/rcell_pkg.sv
package rcell_pkg;

    localparam int DW      = 16;
    localparam int SEL_W   = 3;
    localparam int OP_W    = 3;
    localparam int NBR_N   = 5;
    localparam int SPARE_W = 4;
    localparam int FLAG_N  = 4;
    localparam int CFG_W   = SPARE_W + DW + FLAG_N + OP_W + 2 * SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_N     = 3'd0,
        SRC_NE    = 3'd1,
        SRC_NW    = 3'd2,
        SRC_W     = 3'd3,
        SRC_S     = 3'd4,
        SRC_CONST = 3'd5,
        SRC_FB    = 3'd6,
        SRC_ZERO  = 3'd7
    } src_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_NOT = 3'd5,
        OP_NOR = 3'd6,
        OP_NIL = 3'd7
    } op_e;

    // MSB first: spare, constant, feedback tap, result reg, B reg, A reg, opcode, sel B, sel A
    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic [DW-1:0]      konst;
        logic               fb_reg;
        logic               reg_o;
        logic               reg_b;
        logic               reg_a;
        op_e                op;
        src_e               sel_b;
        src_e               sel_a;
    } cfg_t;

    typedef logic [NBR_N-1:0][DW-1:0] nbr_t;

    function automatic logic [DW-1:0] alu_eval(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [2*DW-1:0] prod;
        logic [DW-1:0]   y;
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DW-1:0];
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = ~a;
            OP_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
        return y;
    endfunction

    function automatic logic [DW-1:0] pick_src(src_e sel, nbr_t nbr, logic [DW-1:0] konst,
                                               logic [DW-1:0] fb);
        logic [DW-1:0] v;
        case (sel)
            SRC_N:     v = nbr[0];
            SRC_NE:    v = nbr[1];
            SRC_NW:    v = nbr[2];
            SRC_W:     v = nbr[3];
            SRC_S:     v = nbr[4];
            SRC_CONST: v = konst;
            SRC_FB:    v = fb;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rcell_cfg_reg.sv
module rcell_cfg_reg
    import rcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] word_in,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_t'(word_in);
        end
    end

endmodule

// File: rtl/rcell_opnd.sv
module rcell_opnd
    import rcell_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  src_e          sel,
    input  logic          reg_en,
    input  logic          fb_reg,
    input  nbr_t          nbr,
    input  logic [DW-1:0] konst,
    input  logic [DW-1:0] fb_live,
    input  logic [DW-1:0] fb_hold,
    output logic [DW-1:0] opnd
);

    logic [DW-1:0] to_reg;
    logic [DW-1:0] direct;
    logic [DW-1:0] held;

    // Register path may see the live result; the direct path only ever sees the held one.
    always_comb begin
        to_reg = pick_src(sel, nbr, konst, fb_reg ? fb_hold : fb_live);
        direct = pick_src(sel, nbr, konst, fb_hold);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= to_reg;
        end
    end

    assign opnd = reg_en ? held : direct;

endmodule

// File: rtl/rcell_alu.sv
module rcell_alu
    import rcell_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        y = alu_eval(op, a, b);
    end

endmodule

// File: rtl/rcell.sv
module rcell
    import rcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctx_switch,
    input  logic [CFG_W-1:0] ctx_word,
    input  logic [DW-1:0]    nb_n,
    input  logic [DW-1:0]    nb_ne,
    input  logic [DW-1:0]    nb_nw,
    input  logic [DW-1:0]    nb_w,
    input  logic [DW-1:0]    nb_s,
    output logic [DW-1:0]    cell_out
);

    localparam int OPND_N = 2;

    cfg_t          cfg;
    nbr_t          nbr;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] out_q;
    logic [DW-1:0] opnd_use [OPND_N];
    logic          unused_spare;

    assign nbr          = {nb_s, nb_w, nb_nw, nb_ne, nb_n};
    assign unused_spare = ^cfg.spare;

    rcell_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (ctx_switch),
        .word_in (ctx_word),
        .cfg_q   (cfg)
    );

    for (genvar g = 0; g < OPND_N; g++) begin : g_opnd
        src_e sel_g;
        logic reg_g;
        assign sel_g = (g == 0) ? cfg.sel_a : cfg.sel_b;
        assign reg_g = (g == 0) ? cfg.reg_a : cfg.reg_b;

        rcell_opnd u_opnd (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel_g),
            .reg_en  (reg_g),
            .fb_reg  (cfg.fb_reg),
            .nbr     (nbr),
            .konst   (cfg.konst),
            .fb_live (alu_y),
            .fb_hold (out_q),
            .opnd    (opnd_use[g])
        );
    end

    rcell_alu u_alu (
        .op (cfg.op),
        .a  (opnd_use[0]),
        .b  (opnd_use[1]),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= alu_y;
        end
    end

    assign cell_out = cfg.reg_o ? out_q : alu_y;

endmodule

// File: rtl/rcell_chk.sv
module rcell_chk
    import rcell_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctx_switch,
    input logic [CFG_W-1:0] ctx_word,
    input cfg_t             cfg_q,
    input logic [DW-1:0]    opa,
    input logic [DW-1:0]    opb,
    input logic [DW-1:0]    alu_y,
    input logic [DW-1:0]    out_q,
    input logic [DW-1:0]    cell_out
);

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctx_switch |=> $stable(cfg_q));

    // R1
    cfg_take_chk: assert property (@(posedge clk) disable iff (rst)
        ctx_switch |=> (cfg_q == cfg_t'($past(ctx_word))));

    // R5
    out_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.reg_o && $past(cfg_q.reg_o)) |-> (cell_out == $past(alu_y)));

    // R3
    add_op_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.op == OP_ADD) |-> (alu_y == opa + opb));

    // R3
    not_op_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.op == OP_NOT) |-> (alu_y == ~opa));

    // R10
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_q == '0));

endmodule

bind rcell rcell_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctx_switch (ctx_switch),
    .ctx_word   (ctx_word),
    .cfg_q      (cfg),
    .opa        (opnd_use[0]),
    .opb        (opnd_use[1]),
    .alu_y      (alu_y),
    .out_q      (out_q),
    .cell_out   (cell_out)
);

// File: tb/rcell_test.sv
module rcell_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctx_switch;
    logic [32:0] ctx_word;
    logic [15:0] nb_n, nb_ne, nb_nw, nb_w, nb_s;
    logic [15:0] cell_out;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rcell uut (
        .clk        (clk),
        .rst        (rst),
        .ctx_switch (ctx_switch),
        .ctx_word   (ctx_word),
        .nb_n       (nb_n),
        .nb_ne      (nb_ne),
        .nb_nw      (nb_nw),
        .nb_w       (nb_w),
        .nb_s       (nb_s),
        .cell_out   (cell_out)
    );

    typedef struct packed {
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic [2:0]  op;
        logic [15:0] n;
        logic [15:0] ne;
        logic [15:0] nw;
        logic [15:0] w;
        logic [15:0] s;
        logic [15:0] k;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    // R2 / R3 / R4 combinational vectors, no registers enabled
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd4, 3'd0, 16'h1234, 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'h0101, 16'h0000, 16'h1335},
        '{3'd1, 3'd3, 3'd1, 16'h1111, 16'h0005, 16'h2222, 16'h0007, 16'h3333, 16'h0000, 16'hFFFE},
        '{3'd2, 3'd5, 3'd2, 16'h4444, 16'h5555, 16'h0123, 16'h6666, 16'h7777, 16'h0100, 16'h2300},
        '{3'd0, 3'd1, 3'd3, 16'hF0F0, 16'hFF00, 16'h1357, 16'h2468, 16'h9999, 16'h0000, 16'hF000},
        '{3'd3, 3'd4, 3'd4, 16'h8888, 16'h7777, 16'h6666, 16'h00F0, 16'h0F00, 16'h0000, 16'h0FF0},
        '{3'd4, 3'd0, 3'd5, 16'h5555, 16'hAAAA, 16'h3C3C, 16'hC3C3, 16'h1234, 16'h0000, 16'hEDCB},
        '{3'd0, 3'd2, 3'd6, 16'h1100, 16'hFFFF, 16'h0011, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hEEEE},
        '{3'd5, 3'd7, 3'd0, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'h1234, 16'hBEEF, 16'hBEEF},
        '{3'd7, 3'd7, 3'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000},
        '{3'd0, 3'd0, 3'd7, 16'h1234, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000},
        '{3'd5, 3'd3, 3'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0010, 16'h000F},
        '{3'd0, 3'd4, 3'd0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 16'h0000, 16'h0001},
        '{3'd0, 3'd4, 3'd2, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'h0010, 16'h0000, 16'h2340}
    };

    function automatic logic [32:0] mk(logic [2:0] sa, logic [2:0] sb, logic [2:0] op,
                                       logic ra, logic rb, logic ro, logic fb,
                                       logic [15:0] k, logic [3:0] spare);
        return {spare, k, fb, ro, rb, ra, op, sb, sa};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: cell_out=%h expected %h", req, act, exp);
        end
    endtask

    // Load a word; returns at the negedge after the capturing edge.
    task automatic load_cfg(input logic [32:0] word);
        @(negedge clk);
        ctx_word   = word;
        ctx_switch = 1'b1;
        @(negedge clk);
        ctx_switch = 1'b0;
    endtask

    task automatic set_nbr(input vec_t v);
        nb_n = v.n; nb_ne = v.ne; nb_nw = v.nw; nb_w = v.w; nb_s = v.s;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            summary();
        end
    end

    initial begin
        logic [15:0] v0, v1, v2;
        rst = 1'b1; ctx_switch = 1'b0; ctx_word = '0;
        nb_n = 16'h0003; nb_ne = 16'h0100; nb_nw = 16'h0200; nb_w = 16'h0300; nb_s = 16'h0400;
        repeat (3) @(negedge clk);
        // R10: zero configuration adds north to itself
        check("R10 reset config", cell_out, 16'h0006);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after release", cell_out, 16'h0006);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            load_cfg(mk(VECS[i].sa, VECS[i].sb, VECS[i].op, 1'b0, 1'b0, 1'b0, 1'b1, VECS[i].k, 4'h0));
            set_nbr(VECS[i]);
            #1;
            check(i >= 11 ? "R4 wrap" : "R2 R3 table", cell_out, VECS[i].exp);
        end

        // R11: spare bits ignored
        load_cfg(mk(3'd0, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 4'hF));
        set_nbr(VECS[0]);
        #1;
        check("R11 spare bits", cell_out, 16'h1335);

        // R5: result register delays by one edge
        load_cfg(mk(3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 4'h0));
        nb_n = 16'h0042;
        @(negedge clk);
        check("R5 registered out", cell_out, 16'h0042);
        nb_n = 16'h0043;
        #1;
        check("R5 holds until edge", cell_out, 16'h0042);
        @(negedge clk);
        check("R5 next edge", cell_out, 16'h0043);

        // R6: operand register
        load_cfg(mk(3'd0, 3'd7, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 4'h0));
        nb_n = 16'h0011;
        @(negedge clk);
        check("R6 operand reg", cell_out, 16'h0011);
        nb_n = 16'h0022;
        #1;
        check("R6 holds until edge", cell_out, 16'h0011);
        @(negedge clk);
        check("R6 next edge", cell_out, 16'h0022);

        // R7: registered feedback accumulates +1
        load_cfg(mk(3'd6, 3'd5, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0001, 4'h0));
        #1; v0 = cell_out;
        @(negedge clk); #1; v1 = cell_out;
        @(negedge clk); #1; v2 = cell_out;
        check("R7 step 1", v1, v0 + 16'd1);
        check("R7 step 2", v2, v1 + 16'd1);

        // R8: live feedback through operand register steps by +2
        load_cfg(mk(3'd6, 3'd5, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0002, 4'h0));
        #1; v0 = cell_out;
        @(negedge clk); #1; v1 = cell_out;
        @(negedge clk); #1; v2 = cell_out;
        check("R8 live step 1", v1, v0 + 16'd2);
        check("R8 live step 2", v2, v1 + 16'd2);

        // R8: live tap with operand bypassed falls back to held result, +3
        load_cfg(mk(3'd6, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003, 4'h0));
        #1; v0 = cell_out;
        @(negedge clk); #1; v1 = cell_out;
        @(negedge clk); #1; v2 = cell_out;
        check("R8 bypass step 1", v1, v0 + 16'd3);
        check("R8 bypass step 2", v2, v1 + 16'd3);

        // R1 / R9: strobe timing and pipeline survival
        load_cfg(mk(3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 4'h0));
        nb_n = 16'h0077;
        @(negedge clk);
        check("R9 old context", cell_out, 16'h0077);
        ctx_word = mk(3'd5, 3'd7, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0500, 4'h0);
        @(negedge clk);
        check("R1 word without strobe", cell_out, 16'h0077);
        ctx_switch = 1'b1;
        #1;
        check("R1 before edge", cell_out, 16'h0077);
        @(negedge clk);
        ctx_switch = 1'b0;
        #1;
        check("R9 pipeline kept", cell_out, 16'h0077);
        @(negedge clk);
        check("R1 new context", cell_out, 16'h0500);

        done = 1'b1;
        summary();
    end

endmodule